// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a slave on a 32-bit host register interface. It presents a window of four registers through which the host reaches a larger back-end register space. The four registers are a command, a target address, the captured read data and the pending write data. The host stages an address, and also write data when it writes, then sets a read or write bit in the command register. The bridge then runs exactly one back-end transfer over a valid/ready handshake. It captures any returned data and raises an acknowledge flag in the command register.

The host polls the command register until the acknowledge appears and collects the result. It then writes zero to the command register, which returns the bridge to rest. The command register then reads back as zero. The host may also place a new command over an access that was left acknowledged but never cleared, and the bridge starts the new transfer at once. Back-end addresses are 12 bits wide, covering system registers 0x000 to 0xFFF. Every access is a full 32-bit word.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the command register reads 0, the read-data register reads 0 and `be_req` is low.
- R2: The window starts at byte offset 0x400. The command register is at 0x400, the address register at 0x404, read data at 0x408 and write data at 0x40C. A host read returns its value with `host_rvalid` one cycle later. The address register keeps and returns only its low 12 bits. Any offset outside the window reads 0.
- R3: Writing command bit 1 (write) alone raises `be_req` with `be_we`=1, carrying the staged address and write data. Once the back end accepts it, command bit 2 (acknowledge) is set.
- R4: Writing command bit 0 (read) raises `be_req` with `be_we`=0. After acceptance, the word returned with `be_rvalid` is captured into the read-data register and the acknowledge bit is set.
- R5: A command with both bit 0 and bit 1 set performs a read, and the back-end contents are not modified.
- R6: While a transfer is pending (requested or awaiting read data), host writes to the command, address and write-data registers are ignored.
- R7: Writing zero to the command register after the acknowledge clears the whole register, so that it reads back 0.
- R8: A read or write command written while the acknowledge is still set starts a new transfer without a clear phase in between.
- R9: The read-data register holds its value until the next completed read. Host writes to it have no effect.
- R10: `be_req`, `be_addr`, `be_we` and `be_wdata` stay constant from the moment the request is raised until `be_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | HOST_AW (16) | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DW (32) | Host write data |
| host_rdata | output | DW (32) | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| be_req | output | 1 | Back-end request, held until be_ready |
| be_we | output | 1 | Back-end write enable |
| be_addr | output | BE_AW (12) | Back-end word address |
| be_wdata | output | DW (32) | Back-end write data |
| be_ready | input | 1 | Back-end accepts the request |
| be_rvalid | input | 1 | Back-end read data valid |
| be_rdata | input | DW (32) | Back-end read data |

## Verification
The hardest case to reach from the ports is a host that acts while a transfer is still pending. Normally the back end accepts within a few cycles, which leaves no time for such writes. The bench model can therefore hold `be_ready` low on demand. While it stalls, the bench rewrites the address, write data and command and checks that the request the back end sees is unchanged. A second hard case is the acknowledged but uncleared state. The bench skips the clear phase and writes a fresh command over it. The main sweep crosses 64 spread addresses with a per-address acceptance latency.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RDWAIT,
        ST_DONE
    } ibr_state_e;

    typedef enum logic [2:0] {
        SEL_CMD,
        SEL_ADDR,
        SEL_RDATA,
        SEL_WDATA,
        SEL_NONE
    } ibr_sel_e;

    // Command register layout: bit 2 ack, bit 1 write, bit 0 read
    typedef struct packed {
        logic ack;
        logic wr;
        logic rd;
    } ibr_cmd_t;

    localparam int CMD_W = 3;

    // Window base must be 16-byte aligned; registers are word aligned.
    function automatic ibr_sel_e ibr_select(input logic [31:0] a, input logic [31:0] base);
        ibr_sel_e s;
        s = SEL_NONE;
        if (a[31:4] == base[31:4] && a[1:0] == 2'b00) begin
            case (a[3:2])
                2'd0:    s = SEL_CMD;
                2'd1:    s = SEL_ADDR;
                2'd2:    s = SEL_RDATA;
                default: s = SEL_WDATA;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ibr_regs.sv
module ibr_regs
    import ibr_pkg::*;
#(
    parameter int          HOST_AW  = 16,
    parameter int          DW       = 32,
    parameter int          BE_AW    = 12,
    parameter logic [31:0] WIN_BASE = 32'h400
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic               host_rvalid,
    input  logic               busy,
    input  ibr_cmd_t           cmd_view,
    input  logic [DW-1:0]      rd_data,
    output logic               cmd_we,
    output logic [1:0]         cmd_bits,
    output logic [BE_AW-1:0]   addr_q,
    output logic [DW-1:0]      wdata_q
);

    localparam int ADDR_PAD = DW - BE_AW;
    localparam int CMD_PAD  = DW - CMD_W;

    ibr_sel_e      sel;
    logic [DW-1:0] view;

    assign sel      = ibr_select(32'(host_addr), WIN_BASE);
    assign cmd_we   = host_wr && sel == SEL_CMD;
    assign cmd_bits = host_wdata[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (host_wr && !busy) begin
            if (sel == SEL_ADDR)  addr_q  <= host_wdata[BE_AW-1:0];
            if (sel == SEL_WDATA) wdata_q <= host_wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_CMD:   view = {{CMD_PAD{1'b0}}, cmd_view};
            SEL_ADDR:  view = {{ADDR_PAD{1'b0}}, addr_q};
            SEL_RDATA: view = rd_data;
            SEL_WDATA: view = wdata_q;
            default:   view = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) host_rdata <= view;
        end
    end

    p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    p_stage_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr) |=> ($stable(addr_q) && $stable(wdata_q)));

endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
#(
    parameter int DW    = 32,
    parameter int BE_AW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [1:0]       cmd_bits,
    input  logic [BE_AW-1:0] addr_q,
    input  logic [DW-1:0]    wdata_q,
    output ibr_cmd_t         cmd_view,
    output logic [DW-1:0]    rd_data,
    output logic             busy,
    output logic             be_req,
    output logic             be_we,
    output logic [BE_AW-1:0] be_addr,
    output logic [DW-1:0]    be_wdata,
    input  logic             be_ready,
    input  logic             be_rvalid,
    input  logic [DW-1:0]    be_rdata
);

    ibr_state_e    state_q;
    ibr_cmd_t      cmd_q;
    logic [DW-1:0] rdata_q;
    logic          accept_new;

    assign accept_new = cmd_we && (state_q == ST_IDLE || state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept_new) begin
                        if (|cmd_bits) begin
                            cmd_q.ack <= 1'b0;
                            cmd_q.rd  <= cmd_bits[0];
                            cmd_q.wr  <= cmd_bits[1] & ~cmd_bits[0];
                            state_q   <= ST_ISSUE;
                        end else begin
                            cmd_q   <= '0;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (be_ready) begin
                        if (cmd_q.wr) begin
                            cmd_q.ack <= 1'b1;
                            state_q   <= ST_DONE;
                        end else begin
                            state_q   <= ST_RDWAIT;
                        end
                    end
                end
                default: begin
                    if (be_rvalid) begin
                        rdata_q   <= be_rdata;
                        cmd_q.ack <= 1'b1;
                        state_q   <= ST_DONE;
                    end
                end
            endcase
        end
    end

    assign busy     = state_q == ST_ISSUE || state_q == ST_RDWAIT;
    assign be_req   = state_q == ST_ISSUE;
    assign be_we    = cmd_q.wr;
    assign be_addr  = addr_q;
    assign be_wdata = wdata_q;
    assign cmd_view = cmd_q;
    assign rd_data  = rdata_q;

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (be_req && !be_ready) |=> (be_req && $stable(be_addr) && $stable(be_we) && $stable(be_wdata)));

    p_ack_after_r3: assert property (@(posedge clk) disable iff (rst)
        be_req |-> !cmd_view.ack);

    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_we) |=> ($stable(cmd_q.rd) && $stable(cmd_q.wr)));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && cmd_we && cmd_bits == 2'b00) |=> (cmd_view == '0 && !busy));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_RDWAIT && be_rvalid) |=> $stable(rd_data));

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int          HOST_AW  = 16,
    parameter int          DW       = 32,
    parameter int          BE_AW    = 12,
    parameter logic [31:0] WIN_BASE = 32'h400
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic               host_rvalid,
    output logic               be_req,
    output logic               be_we,
    output logic [BE_AW-1:0]   be_addr,
    output logic [DW-1:0]      be_wdata,
    input  logic               be_ready,
    input  logic               be_rvalid,
    input  logic [DW-1:0]      be_rdata
);

    logic             busy;
    ibr_cmd_t         cmd_view;
    logic [DW-1:0]    rd_data;
    logic             cmd_we;
    logic [1:0]       cmd_bits;
    logic [BE_AW-1:0] addr_q;
    logic [DW-1:0]    wdata_q;

    ibr_regs #(
        .HOST_AW (HOST_AW),
        .DW      (DW),
        .BE_AW   (BE_AW),
        .WIN_BASE(WIN_BASE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid),
        .busy       (busy),
        .cmd_view   (cmd_view),
        .rd_data    (rd_data),
        .cmd_we     (cmd_we),
        .cmd_bits   (cmd_bits),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q)
    );

    ibr_seq #(
        .DW   (DW),
        .BE_AW(BE_AW)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd_we),
        .cmd_bits (cmd_bits),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .cmd_view (cmd_view),
        .rd_data  (rd_data),
        .busy     (busy),
        .be_req   (be_req),
        .be_we    (be_we),
        .be_addr  (be_addr),
        .be_wdata (be_wdata),
        .be_ready (be_ready),
        .be_rvalid(be_rvalid),
        .be_rdata (be_rdata)
    );

endmodule

// File: tb/ibr_bridge_bench.sv
module ibr_bridge_bench;

    localparam int NW = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        be_req, be_we, be_ready;
    logic [11:0] be_addr;
    logic [31:0] be_wdata;
    logic        be_rvalid = 1'b0;
    logic [31:0] be_rdata = '0;

    logic [31:0] mem [NW];
    logic [31:0] expv [NW];
    logic        stall = 1'b0;
    int          wait_cnt = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    ibr_bridge u_ibr_bridge (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .be_req(be_req), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata),
        .be_ready(be_ready), .be_rvalid(be_rvalid), .be_rdata(be_rdata)
    );

    // Back-end model: acceptance latency equals be_addr[1:0] cycles
    assign be_ready = be_req && !stall && (wait_cnt >= int'(be_addr[1:0]));

    always @(posedge clk) begin
        if (be_req && !be_ready) wait_cnt <= wait_cnt + 1;
        else                     wait_cnt <= 0;
        be_rvalid <= 1'b0;
        if (be_req && be_ready) begin
            if (be_we) mem[be_addr] <= be_wdata;
            else begin
                be_rvalid <= 1'b1;
                be_rdata  <= mem[be_addr];
            end
        end
    end

    function automatic logic [31:0] seed(input int i);
        return (i * 32'h0001_0003) ^ 32'h5A00_0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic poll_ack(input string req);
        logic [31:0] c;
        bit ok;
        ok = 1'b0;
        for (int n = 0; n < 300 && !ok; n++) begin
            hread(16'h400, c);
            if (c[2]) ok = 1'b1;
        end
        chk(req, {31'd0, ok}, 32'd1);
    endtask

    task automatic clear_cmd(input string req);
        logic [31:0] c;
        hwrite(16'h400, 32'd0);
        hread(16'h400, c);
        chk(req, c, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] keep;
        logic [11:0] a;
        for (int i = 0; i < NW; i++) begin
            mem[i]  = seed(i);
            expv[i] = seed(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hread(16'h400, r); chk("R1 cmd", r, 32'd0);
        hread(16'h408, r); chk("R1 rdata", r, 32'd0);
        chk("R1 be_req", {31'd0, be_req}, 32'd0);

        // R2 decode and readback
        hwrite(16'h404, 32'hFFFF_FABC);
        hread(16'h404, r); chk("R2 addr low bits", r, 32'h0000_0ABC);
        chk("R2 rvalid", {31'd0, host_rvalid}, 32'd1);
        hwrite(16'h40C, 32'hDEAD_BEEF);
        hread(16'h40C, r); chk("R2 wdata", r, 32'hDEAD_BEEF);
        hread(16'h410, r); chk("R2 outside", r, 32'd0);
        hread(16'h000, r); chk("R2 outside low", r, 32'd0);

        // R3 write sweep, R7 clear after each
        for (int i = 0; i < 64; i++) begin
            a = 12'(i * 64 + i);
            hwrite(16'h40C, 32'hC0DE_0000 + 32'(i * 7));
            hwrite(16'h404, 32'(a));
            hwrite(16'h400, 32'd2);
            poll_ack("R3 write ack");
            expv[a] = 32'hC0DE_0000 + 32'(i * 7);
            chk("R3 mem written", mem[a], expv[a]);
            clear_cmd("R7 cleared");
        end

        // R4 read sweep over written and untouched words
        for (int i = 0; i < 64; i++) begin
            for (int k = 0; k < 2; k++) begin
                a = 12'(i * 64 + (k == 0 ? i : 32));
                hwrite(16'h404, 32'(a));
                hwrite(16'h400, 32'd1);
                poll_ack("R4 read ack");
                hread(16'h408, r); chk("R4 read data", r, expv[a]);
                clear_cmd("R7 cleared after read");
            end
        end

        // R5 both bits set reads and leaves memory alone
        hwrite(16'h40C, 32'h1234_5678);
        hwrite(16'h404, 32'h0777);
        hwrite(16'h400, 32'd3);
        poll_ack("R5 ack");
        hread(16'h408, r); chk("R5 read data", r, expv[12'h777]);
        chk("R5 memory untouched", mem[12'h777], expv[12'h777]);
        clear_cmd("R7 after R5");

        // R6 and R10: host writes during a stalled request
        stall = 1'b1;
        hwrite(16'h40C, 32'h1111_1111);
        hwrite(16'h404, 32'h0100);
        hwrite(16'h400, 32'd2);
        hwrite(16'h404, 32'h0200);
        hwrite(16'h40C, 32'h2222_2222);
        hwrite(16'h400, 32'd1);
        chk("R10 be_addr held", 32'(be_addr), 32'h100);
        chk("R10 be_we held", {31'd0, be_we}, 32'd1);
        chk("R10 be_wdata held", be_wdata, 32'h1111_1111);
        hread(16'h404, r); chk("R6 addr unchanged", r, 32'h100);
        hread(16'h40C, r); chk("R6 wdata unchanged", r, 32'h1111_1111);
        hread(16'h400, r); chk("R6 cmd unchanged", r, 32'd2);
        stall = 1'b0;
        poll_ack("R6 ack");
        expv[12'h100] = 32'h1111_1111;
        chk("R6 mem at old addr", mem[12'h100], 32'h1111_1111);
        chk("R6 new addr untouched", mem[12'h200], expv[12'h200]);
        clear_cmd("R7 after R6");

        // R8 fresh command over an unfinished access
        hwrite(16'h404, 32'h0123);
        hwrite(16'h400, 32'd1);
        poll_ack("R8 first ack");
        hwrite(16'h404, 32'h0100);
        hwrite(16'h400, 32'd1);
        poll_ack("R8 second ack");
        hread(16'h408, r); chk("R8 new read data", r, expv[12'h100]);

        // R9 rdata write ignored, value kept across clear and a write
        keep = r;
        hwrite(16'h408, 32'hFFFF_0000);
        hread(16'h408, r); chk("R9 write ignored", r, keep);
        clear_cmd("R7 after R8");
        hwrite(16'h40C, 32'h0BAD_F00D);
        hwrite(16'h404, 32'h0050);
        hwrite(16'h400, 32'd2);
        poll_ack("R9 write ack");
        hread(16'h408, r); chk("R9 held over write", r, keep);
        clear_cmd("R7 final");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule